// File: doc/BRIEF.md
# Calendar Time Counter with BCD or Binary Fields

The block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month, two-digit year and a century count. It moves forward by one second on each single-cycle pulse of `secTick`. Software reads and writes the fields as bytes on a small register bus. Each byte is shown in packed BCD or in plain binary, as a mode bit selects. Hours are shown in 24-hour form or in 12-hour form with a PM flag.

Each step is announced by an update-in-progress status bit, which stays high for a fixed window of clock cycles. The carry into the fields happens on the last edge of that window. The `updEnded` output gives a one-cycle pulse on the same edge. A hold bit stops all stepping, so software can load a consistent new time. Internally every field is kept as a binary count, and the bus converts it to the selected format on each access. Changing the mode therefore shows the same instant in the new format.

Top module: `calTimeCounter`

## Requirements
- R1: After reset the fields hold 00:00:00, weekday 1, day 1, month 1, year 0 and century 20. The mode byte at 0x0B reads 0x02, which is BCD, 24-hour and running. The status byte at 0x0A reads 0x00.
- R2: The byte map is: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day of month 0x07, month 0x08, year 0x09, status 0x0A, mode 0x0B and century 0x48. Every other address reads 0x00, and a write to it has no effect.
- R3: A `secTick` pulse seen on a rising edge while the hold bit is 0 and no step is pending sets status bit 7 (update in progress, also on `updInProg`). The bit stays set for exactly UIP_CYCLES cycles. The time fields advance by one second on the edge where it clears.
- R4: `updEnded` is high for exactly one cycle, starting on the edge where `updInProg` falls after a completed step. A `secTick` that arrives while a step is pending is ignored.
- R5: Seconds wrap 59→0 and carry into minutes. Minutes wrap 59→0 and carry into hours. Hours wrap 23→0 and advance both the weekday and the day of month. The weekday counts 1..7 and wraps 7→1.
- R6: The day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. February ends after day 29 when the year is divisible by four, year 0 included, and after day 28 otherwise.
- R7: The month wraps 12→1 and carries into the year. The year wraps 99→0 and increments the century. The century wraps 99→0.
- R8: Bit 2 of the mode byte selects the field format: 0 is packed BCD (tens in bits 7:4, units in bits 3:0) and 1 is binary. The same format applies to reads and writes. Switching the bit re-encodes the stored time and does not change it.
- R9: Bit 1 of the mode byte set selects 24-hour hours, 0..23. When it is clear, hours read and write as 1..12 with bit 7 set for PM. The sequence runs 11 AM → 12 PM (0x92 in BCD) → 1 PM and 11 PM → 12 AM (0x12).
- R10: While bit 7 of the mode byte (hold) is 1, ticks are ignored. If hold becomes 1 while a step is pending, that step is dropped: no field changes and no `updEnded` pulse.
- R11: Bits 6:0 of the status byte read 0, and writes to the status byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse marking a second |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 7 | Byte address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |
| updInProg | output | 1 | High while a one-second step is pending |
| updEnded | output | 1 | One-cycle pulse when a step completes |

## Verification
The range assertions assume that software writes only legal values for the format that is selected: BCD digits, 1..12 hours in 12-hour form, and days that exist in the month. The stimulus writes only such values. The bench changes fields only while hold is set or no step is pending, so writes and carries never meet in the same cycle. Ticks are single-cycle pulses. The bench places some ticks inside a pending window on purpose, and places one abort on the cycle after a tick, to exercise the cases where a tick is ignored and a step is dropped.

// File: rtl/calTimePkg.sv
package calTimePkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] ADDR_SEC   = 7'h00;
  localparam logic [ADDR_W-1:0] ADDR_MIN   = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_HOUR  = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_WDAY  = 7'h06;
  localparam logic [ADDR_W-1:0] ADDR_MDAY  = 7'h07;
  localparam logic [ADDR_W-1:0] ADDR_MON   = 7'h08;
  localparam logic [ADDR_W-1:0] ADDR_YEAR  = 7'h09;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 7'h0A;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 7'h0B;
  localparam logic [ADDR_W-1:0] ADDR_CENT  = 7'h48;

  // Strobes from control to datapath
  typedef struct packed {
    logic applyStep;
  } calStrobeT;

  // Bus byte to binary count
  function automatic logic [6:0] fromReg(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  // Binary count to bus byte
  function automatic logic [7:0] toReg(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [4:0] daysIn(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2: return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default: return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calTimePkg::*;
#(
  parameter int UIP_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      secTick,
  input  logic      hold,
  output calStrobeT strobe,
  output logic      uip,
  output logic      endPulse
);
  localparam int CNT_W = $clog2(UIP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(UIP_CYCLES - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cnt      <= '0;
      endPulse <= 1'b0;
    end else begin
      endPulse <= 1'b0;
      if (hold) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (cnt == '0) begin
          busy     <= 1'b0;
          endPulse <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (secTick) begin
        busy <= 1'b1;
        cnt  <= CNT_LOAD;
      end
    end
  end

  always_comb begin
    strobe.applyStep = busy && (cnt == '0) && !hold;
    uip              = busy;
  end

  // R4
  end_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |=> !endPulse);

  // R4
  end_after_uip_chk: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |-> (!uip && $past(uip)));

  // R10
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> !uip);

  // R3
  tick_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !uip && !hold) |=> uip);
endmodule

// File: rtl/calData.sv
module calData
  import calTimePkg::*;
#(
  parameter int CENTURY_RST = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  calStrobeT         strobe,
  input  logic              uipIn,
  output logic              hold
);
  logic [6:0] secQ, minQ, yearQ, centQ;
  logic [4:0] hourQ, mdayQ;
  logic [3:0] monQ;
  logic [2:0] wdayQ;
  logic [7:0] modeQ;

  logic binMode, h24;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, yearWrap;
  logic [6:0] wrVal, hrRaw, hr12Base, hourWr, hourOut12;
  logic [7:0] hourRd;

  always_comb begin
    binMode  = modeQ[2];
    h24      = modeQ[1];
    hold     = modeQ[7];
    secWrap  = secQ == 7'd59;
    minWrap  = secWrap && (minQ == 7'd59);
    hourWrap = minWrap && (hourQ == 5'd23);
    dayWrap  = hourWrap && (mdayQ == daysIn(monQ, yearQ));
    monWrap  = dayWrap && (monQ == 4'd12);
    yearWrap = monWrap && (yearQ == 7'd99);

    wrVal    = fromReg(wrData, binMode);
    hrRaw    = h24 ? wrVal : fromReg({1'b0, wrData[6:0]}, binMode);
    hr12Base = (hrRaw == 7'd12) ? 7'd0 : hrRaw;
    hourWr   = h24 ? hrRaw : (hr12Base + (wrData[7] ? 7'd12 : 7'd0));

    if (hourQ == 5'd0)       hourOut12 = 7'd12;
    else if (hourQ > 5'd12)  hourOut12 = 7'(hourQ) - 7'd12;
    else                     hourOut12 = 7'(hourQ);
    hourRd = h24 ? toReg(7'(hourQ), binMode)
                 : {hourQ >= 5'd12, 7'(toReg(hourOut12, binMode))};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      wdayQ <= 3'd1;
      mdayQ <= 5'd1;
      monQ  <= 4'd1;
      yearQ <= '0;
      centQ <= 7'(CENTURY_RST);
      modeQ <= 8'h02;
    end else begin
      if (strobe.applyStep) begin
        secQ <= secWrap ? 7'd0 : secQ + 7'd1;
        if (secWrap)  minQ  <= minWrap ? 7'd0 : minQ + 7'd1;
        if (minWrap)  hourQ <= hourWrap ? 5'd0 : hourQ + 5'd1;
        if (hourWrap) begin
          wdayQ <= (wdayQ == 3'd7) ? 3'd1 : wdayQ + 3'd1;
          mdayQ <= dayWrap ? 5'd1 : mdayQ + 5'd1;
        end
        if (dayWrap)  monQ  <= monWrap ? 4'd1 : monQ + 4'd1;
        if (monWrap)  yearQ <= yearWrap ? 7'd0 : yearQ + 7'd1;
        if (yearWrap) centQ <= (centQ == 7'd99) ? 7'd0 : centQ + 7'd1;
      end
      if (wrEn) begin
        case (addr)
          ADDR_SEC:  secQ  <= wrVal;
          ADDR_MIN:  minQ  <= wrVal;
          ADDR_HOUR: hourQ <= 5'(hourWr);
          ADDR_WDAY: wdayQ <= 3'(wrVal);
          ADDR_MDAY: mdayQ <= 5'(wrVal);
          ADDR_MON:  monQ  <= 4'(wrVal);
          ADDR_YEAR: yearQ <= wrVal;
          ADDR_CENT: centQ <= wrVal;
          ADDR_MODE: modeQ <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_SEC:  rdData = toReg(secQ, binMode);
      ADDR_MIN:  rdData = toReg(minQ, binMode);
      ADDR_HOUR: rdData = hourRd;
      ADDR_WDAY: rdData = toReg(7'(wdayQ), binMode);
      ADDR_MDAY: rdData = toReg(7'(mdayQ), binMode);
      ADDR_MON:  rdData = toReg(7'(monQ), binMode);
      ADDR_YEAR: rdData = toReg(yearQ, binMode);
      ADDR_CENT: rdData = toReg(centQ, binMode);
      ADDR_STAT: rdData = {uipIn, 7'd0};
      ADDR_MODE: rdData = modeQ;
      default:   rdData = 8'h00;
    endcase
  end

  // R5
  time_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secQ <= 7'd59) && (minQ <= 7'd59) && (hourQ <= 5'd23) &&
    (wdayQ >= 3'd1) && (mdayQ >= 5'd1) && (mdayQ <= 5'd31));

  // R7
  date_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monQ >= 4'd1) && (monQ <= 4'd12) && (yearQ <= 7'd99) && (centQ <= 7'd99));

  // R10
  sec_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.applyStep && !wrEn) |=> $stable(secQ));
endmodule

// File: rtl/calTimeCounter.sv
module calTimeCounter
  import calTimePkg::*;
#(
  parameter int UIP_CYCLES  = 4,
  parameter int CENTURY_RST = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              updInProg,
  output logic              updEnded
);
  calStrobeT strobe;
  logic      hold;

  calCtrl #(.UIP_CYCLES(UIP_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .hold     (hold),
    .strobe   (strobe),
    .uip      (updInProg),
    .endPulse (updEnded)
  );

  calData #(.CENTURY_RST(CENTURY_RST)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (busWrEn),
    .addr   (busAddr),
    .wrData (busWrData),
    .rdData (busRdData),
    .strobe (strobe),
    .uipIn  (updInProg),
    .hold   (hold)
  );
endmodule

// File: tb/test_calTimeCounter.sv
module test_calTimeCounter;
  localparam int UIPC = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       busWrEn = 1'b0;
  logic [6:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       updInProg, updEnded;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  calTimeCounter #(.UIP_CYCLES(UIPC), .CENTURY_RST(20)) i_calTimeCounter (
    .clk(clk), .rstN(rstN), .secTick(secTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .updInProg(updInProg), .updEnded(updEnded)
  );

  // Behavioural reference model
  int mSec, mMin, mHour, mWday, mMday, mMon, mYear, mCent, mMode;
  bit mBusy, mEnd;
  int mCnt;

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int v, bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dec(int b, bit bin);
    return bin ? (b % 128) : ((b / 16) * 10 + (b % 16));
  endfunction

  function automatic int modelRead(int a);
    bit bin = mMode[2];
    int h;
    case (a)
      'h00: return enc(mSec, bin);
      'h02: return enc(mMin, bin);
      'h04: begin
        if (mMode[1]) return enc(mHour, bin);
        h = mHour % 12;
        if (h == 0) h = 12;
        return enc(h, bin) + ((mHour >= 12) ? 128 : 0);
      end
      'h06: return enc(mWday, bin);
      'h07: return enc(mMday, bin);
      'h08: return enc(mMon, bin);
      'h09: return enc(mYear, bin);
      'h0A: return mBusy ? 128 : 0;
      'h0B: return mMode;
      'h48: return enc(mCent, bin);
      default: return 0;
    endcase
  endfunction

  task automatic stepModel();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mWday = (mWday == 7) ? 1 : mWday + 1;
          mMday++;
          if (mMday > dim(mMon, mYear)) begin
            mMday = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYear++;
              if (mYear == 100) begin
                mYear = 0;
                mCent = (mCent == 99) ? 0 : mCent + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic writeModel(int a, int d);
    bit bin = mMode[2];
    int v = dec(d, bin);
    int h;
    case (a)
      'h00: mSec = v;
      'h02: mMin = v;
      'h04: begin
        if (mMode[1]) mHour = v;
        else begin
          h = dec(d % 128, bin);
          if (h == 12) h = 0;
          mHour = h + ((d >= 128) ? 12 : 0);
        end
      end
      'h06: mWday = v;
      'h07: mMday = v;
      'h08: mMon = v;
      'h09: mYear = v;
      'h0B: mMode = d;
      'h48: mCent = v;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit doStep;
    bit newEnd;
    if (!rstN) begin
      mSec = 0; mMin = 0; mHour = 0; mWday = 1; mMday = 1; mMon = 1;
      mYear = 0; mCent = 20; mMode = 'h02; mBusy = 0; mEnd = 0; mCnt = 0;
    end else begin
      doStep = mBusy && (mCnt == 0) && !mMode[7];
      newEnd = 0;
      if (mMode[7]) mBusy = 0;
      else if (mBusy) begin
        if (mCnt == 0) begin mBusy = 0; newEnd = 1; end
        else mCnt--;
      end else if (secTick) begin
        mBusy = 1; mCnt = UIPC - 1;
      end
      mEnd = newEnd;
      if (doStep) stepModel();
      if (busWrEn) writeModel(busAddr, busWrData);
    end
  end

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      checks++;
      if (updInProg !== mBusy) begin
        errors++;
        $display("FAIL R3 updInProg actual=%0b expected=%0b", updInProg, mBusy);
      end
      checks++;
      if (updEnded !== mEnd) begin
        errors++;
        $display("FAIL R4 updEnded actual=%0b expected=%0b", updEnded, mEnd);
      end
      checks++;
      if (busRdData !== 8'(modelRead(busAddr))) begin
        errors++;
        $display("FAIL R2 read addr=%h actual=%h expected=%h",
                 busAddr, busRdData, 8'(modelRead(busAddr)));
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic expectRead(input logic [6:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #2;
    checks++;
    if (busRdData !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, busRdData, exp);
    end
  endtask

  task automatic loadClock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(7'h04, h); wr(7'h02, m); wr(7'h00, s);
  endtask

  task automatic runStep();
    pulseTick();
    repeat (UIPC + 2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    expectRead(7'h0B, 8'h02, "R1");
    expectRead(7'h48, 8'h20, "R1");
    expectRead(7'h06, 8'h01, "R1");
    expectRead(7'h04, 8'h00, "R1");
    expectRead(7'h0A, 8'h00, "R1");

    // R5 R7 full rollover, with R10 tick under hold
    wr(7'h0B, 8'h82);
    loadClock(8'h23, 8'h59, 8'h59);
    wr(7'h06, 8'h07); wr(7'h07, 8'h31); wr(7'h08, 8'h12);
    wr(7'h09, 8'h99); wr(7'h48, 8'h20);
    runStep();
    expectRead(7'h00, 8'h59, "R10");
    wr(7'h0B, 8'h02);
    pulseTick();
    busAddr = 7'h0A; #2;
    checks++;
    if (busRdData !== 8'h80) begin
      errors++;
      $display("FAIL R3 status actual=%h expected=80", busRdData);
    end
    repeat (UIPC + 2) @(negedge clk);
    expectRead(7'h00, 8'h00, "R5");
    expectRead(7'h04, 8'h00, "R5");
    expectRead(7'h06, 8'h01, "R5");
    expectRead(7'h07, 8'h01, "R6");
    expectRead(7'h08, 8'h01, "R7");
    expectRead(7'h09, 8'h00, "R7");
    expectRead(7'h48, 8'h21, "R7");

    // R6 leap February
    wr(7'h0B, 8'h82);
    wr(7'h09, 8'h24); wr(7'h08, 8'h02); wr(7'h07, 8'h28);
    loadClock(8'h23, 8'h59, 8'h59);
    wr(7'h0B, 8'h02);
    runStep();
    expectRead(7'h07, 8'h29, "R6");
    wr(7'h0B, 8'h82);
    loadClock(8'h23, 8'h59, 8'h59);
    wr(7'h0B, 8'h02);
    runStep();
    expectRead(7'h07, 8'h01, "R6");
    expectRead(7'h08, 8'h03, "R6");
    // R6 common February and 30-day month
    wr(7'h0B, 8'h82);
    wr(7'h09, 8'h23); wr(7'h08, 8'h02); wr(7'h07, 8'h28);
    loadClock(8'h23, 8'h59, 8'h59);
    wr(7'h0B, 8'h02);
    runStep();
    expectRead(7'h08, 8'h03, "R6");
    wr(7'h0B, 8'h82);
    wr(7'h08, 8'h04); wr(7'h07, 8'h30);
    loadClock(8'h23, 8'h59, 8'h59);
    wr(7'h0B, 8'h02);
    runStep();
    expectRead(7'h07, 8'h01, "R6");
    expectRead(7'h08, 8'h05, "R6");

    // R8 binary write, BCD read of same value
    wr(7'h0B, 8'h86);
    wr(7'h00, 8'h2D);
    expectRead(7'h00, 8'h2D, "R8");
    wr(7'h0B, 8'h82);
    expectRead(7'h00, 8'h45, "R8");

    // R10 abort of a pending step
    wr(7'h0B, 8'h02);
    pulseTick();
    wr(7'h0B, 8'h82);
    repeat (UIPC + 4) @(negedge clk);
    expectRead(7'h00, 8'h45, "R10");

    // R4 tick during a pending step is ignored
    wr(7'h0B, 8'h02);
    pulseTick();
    pulseTick();
    repeat (UIPC + 3) @(negedge clk);
    expectRead(7'h00, 8'h46, "R4");

    // R11 status writes ignored, R2 unmapped addresses
    wr(7'h0A, 8'hFF);
    expectRead(7'h0A, 8'h00, "R11");
    expectRead(7'h30, 8'h00, "R2");
    expectRead(7'h01, 8'h00, "R2");

    // R9 twelve-hour sequence
    wr(7'h0B, 8'h80);
    loadClock(8'h11, 8'h59, 8'h59);
    wr(7'h0B, 8'h00);
    runStep();
    expectRead(7'h04, 8'h92, "R9");
    wr(7'h0B, 8'h80);
    loadClock(8'h91, 8'h59, 8'h59);
    wr(7'h0B, 8'h00);
    runStep();
    expectRead(7'h04, 8'h12, "R9");
    wr(7'h0B, 8'h02);
    expectRead(7'h04, 8'h00, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule